// File: doc/BRIEF.md
# Processor Power Mode Controller

This block is the state machine that moves a processor between five power modes: Full On, Active, Sleep, Deep Sleep and Hibernate. Software drives it with mode requests and with writes to three control fields: the PLL enable and bypass bits, a regulator frequency field, and a clock-multiplier value. Wake sources bring it back out of the low-power modes. Its outputs are plain enables. They gate the core clock and the system clock, turn the PLL on, power the internal supply, put the pads into three-state and permit DMA into L1 memory. It also drives the clock multiplier that is currently in force. Clock generation, regulation and memory retention are outside the block. They are represented only by these enables.

The states are FULL_ON, ACTIVE, SLEEP, DEEP_SLEEP and HIBERNATE. The transitions are as follows. A request moves the controller from FULL_ON or ACTIVE to any of FULL_ON, ACTIVE, SLEEP or DEEP_SLEEP. A write of zero to the regulator field moves it from FULL_ON or ACTIVE to HIBERNATE. A wake in SLEEP leads to FULL_ON or to ACTIVE, chosen by the bypass bit. An RTC wake in DEEP_SLEEP leads to ACTIVE. A wake in HIBERNATE leads to FULL_ON. The reset input leads to FULL_ON from any state. Every wake input is asynchronous and passes through a two-flop synchronizer before the state machine sees it.

Top module: `pwr_mode_ctrl`

## Requirements
- R1: Asynchronous reset (rst_n low) forces mode FULL_ON (code 0) at once from any state. It also sets pll_on=1 and pll_bypass=0, turns on both clocks and the core supply, sets pads_hiz=0, sets mult_cur to MULT_RST (default 4) and clears state_lost.
- R2: A request (req_valid with req_code 0=FULL_ON, 1=ACTIVE, 2=SLEEP, 3=DEEP_SLEEP) is acted on only in FULL_ON or ACTIVE, and takes effect at the next rising edge. Codes 4 to 7 are ignored, and requests made in any other mode are ignored.
- R3: The mode output uses the codes 0=FULL_ON, 1=ACTIVE, 2=SLEEP, 3=DEEP_SLEEP, 4=HIBERNATE. The outputs {cclk_en, sclk_en, vdd_int_en, pads_hiz, dma_l1_ok} per mode are: FULL_ON and ACTIVE 11101, SLEEP 01100, DEEP_SLEEP 00100, HIBERNATE 00010.
- R4: In SLEEP, wake_gen or wake_rtc ends the sleep. The next mode is FULL_ON when pll_bypass is 0 and ACTIVE when it is 1.
- R5: In DEEP_SLEEP only wake_rtc has an effect, and it leads to ACTIVE. wake_gen, wake_can, wake_bus and wake_gp are ignored.
- R6: A write (vr_we) of 2'b00 to vr_freq in FULL_ON or ACTIVE enters HIBERNATE. This write takes priority over a request made in the same cycle. A write of any other value leaves the mode unchanged.
- R7: In HIBERNATE, wake_rtc, wake_can, wake_bus or wake_gp leads to FULL_ON, and wake_gen is ignored. Leaving HIBERNATE sets pll_on=1, pll_bypass=0 and mult_cur=MULT_RST, and sets state_lost to 1. state_lost stays at 1 until reset.
- R8: A PLL write (pll_wr) updates pll_bypass in FULL_ON or ACTIVE. It may clear the PLL enable only in ACTIVE; in FULL_ON the PLL stays enabled. pll_on is 0 in DEEP_SLEEP and HIBERNATE.
- R9: While the PLL is disabled, requests for FULL_ON or SLEEP are refused and the mode stays ACTIVE.
- R10: A multiplier write (mult_we) in FULL_ON or ACTIVE is held as pending. mult_cur takes the pending value only when FULL_ON is entered from another mode.
- R11: dma_l1_ok is 1 only in FULL_ON and ACTIVE.
- R12: A wake input that is high at rising edge n changes the mode at rising edge n+2, and not earlier.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Asynchronous reset, active low; also acts as the reset wake |
| req_valid | input | 1 | Mode request strobe |
| req_code | input | 3 | Requested mode |
| vr_we | input | 1 | Regulator field write strobe |
| vr_freq | input | 2 | Regulator frequency value; 00 enters Hibernate |
| pll_wr | input | 1 | PLL control write strobe |
| pll_wr_en | input | 1 | PLL enable value to write |
| pll_wr_byp | input | 1 | PLL bypass value to write |
| mult_we | input | 1 | Multiplier write strobe |
| mult_wr | input | MW | Multiplier value to write |
| wake_gen | input | 1 | Generic wakeup, asynchronous |
| wake_rtc | input | 1 | RTC interrupt or wakeup, asynchronous |
| wake_can | input | 1 | CAN activity, asynchronous |
| wake_bus | input | 1 | Bus-receive-on pin, asynchronous |
| wake_gp | input | 1 | General-purpose wake, asynchronous |
| mode | output | 3 | Current mode code |
| cclk_en | output | 1 | Core clock enable |
| sclk_en | output | 1 | System clock enable |
| pll_on | output | 1 | PLL enable |
| pll_bypass | output | 1 | Current PLL bypass bit |
| vdd_int_en | output | 1 | Core supply enable |
| pads_hiz | output | 1 | Three-state the external pads |
| dma_l1_ok | output | 1 | DMA to L1 permitted |
| mult_cur | output | MW | Multiplier in force |
| state_lost | output | 1 | Internal state was lost through Hibernate |

## Verification
The bench checks that wake sources are filtered by mode. It shows that wake_gen and wake_can have no effect in Deep Sleep and that wake_gen has no effect in Hibernate; a controller that did not filter them would leave those modes on the wrong wake. The bench disables the PLL and then asks for Full On and Sleep. A design without the PLL guard would enter a clocked mode that has no PLL running. It writes the multiplier and then moves through Active before entering Full On, which catches a multiplier applied as soon as it is written. It also measures wake latency edge by edge, because a missing or extra synchronizer stage shifts the mode change by one cycle. Finally it checks that a Hibernate write wins over a request made in the same cycle.

// File: rtl/pmc_pkg.sv
package pmc_pkg;
    typedef enum logic [2:0] {
        PM_FULL   = 3'd0,
        PM_ACTIVE = 3'd1,
        PM_SLEEP  = 3'd2,
        PM_DEEP   = 3'd3,
        PM_HIBER  = 3'd4
    } pmode_e;

    localparam int unsigned NWAKE = 5;
    localparam int unsigned W_GEN = 0;
    localparam int unsigned W_RTC = 1;
    localparam int unsigned W_CAN = 2;
    localparam int unsigned W_BUS = 3;
    localparam int unsigned W_GP  = 4;

    typedef struct packed {
        logic cclk;
        logic sclk;
        logic vdd;
        logic hiz;
        logic dma;
    } rails_t;
endpackage

// File: rtl/pmc_sync.sv
module pmc_sync #(
    parameter int unsigned N      = 5,
    parameter int unsigned STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] d,
    output logic [N-1:0] q
);
    localparam int unsigned LAST = STAGES - 1;

    for (genvar b = 0; b < N; b++) begin : g_bit
        logic [STAGES-1:0] chain;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                chain <= '0;
            end else begin
                chain <= {chain[STAGES-2:0], d[b]};
            end
        end
        assign q[b] = chain[LAST];
    end
endmodule

// File: rtl/pmc_fsm.sv
module pmc_fsm
    import pmc_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_valid,
    input  logic [2:0]       req_code,
    input  logic             vr_we,
    input  logic [1:0]       vr_freq,
    input  logic             pll_en_q,
    input  logic             byp_q,
    input  logic [NWAKE-1:0] wk,
    output pmode_e           st,
    output pmode_e           nxt
);
    logic running;
    logic hib_cmd;
    logic sleep_wake;
    logic hib_wake;

    assign running    = (st == PM_FULL) || (st == PM_ACTIVE);
    assign hib_cmd    = vr_we && (vr_freq == 2'b00);
    assign sleep_wake = wk[W_GEN] || wk[W_RTC];
    assign hib_wake   = wk[W_RTC] || wk[W_CAN] || wk[W_BUS] || wk[W_GP];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st <= PM_FULL;
        end else begin
            st <= nxt;
        end
    end

    always_comb begin
        nxt = st;
        unique case (st)
            PM_FULL, PM_ACTIVE: begin
                if (hib_cmd) begin
                    nxt = PM_HIBER;
                end else if (req_valid) begin
                    case (req_code)
                        3'd0:    if (pll_en_q) nxt = PM_FULL;
                        3'd1:    nxt = PM_ACTIVE;
                        3'd2:    if (pll_en_q) nxt = PM_SLEEP;
                        3'd3:    nxt = PM_DEEP;
                        default: nxt = st;
                    endcase
                end
            end
            PM_SLEEP: begin
                if (sleep_wake) nxt = byp_q ? PM_ACTIVE : PM_FULL;
            end
            PM_DEEP: begin
                if (wk[W_RTC]) nxt = PM_ACTIVE;
            end
            PM_HIBER: begin
                if (hib_wake) nxt = PM_FULL;
            end
            default: nxt = PM_FULL;
        endcase
    end
    assign unused_ok = running;
    logic unused_ok;
endmodule

// File: rtl/pmc_cfg.sv
module pmc_cfg
    import pmc_pkg::*;
#(
    parameter int unsigned MW       = 4,
    parameter int unsigned MULT_RST = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  pmode_e        st,
    input  pmode_e        nxt,
    input  logic          pll_wr,
    input  logic          pll_wr_en,
    input  logic          pll_wr_byp,
    input  logic          mult_we,
    input  logic [MW-1:0] mult_wr,
    output logic          pll_en_q,
    output logic          byp_q,
    output logic [MW-1:0] mult_cur,
    output logic          lost
);
    localparam logic [MW-1:0] MRST = MW'(MULT_RST);

    logic          running;
    logic          hib_exit;
    logic          full_entry;
    logic [MW-1:0] mult_pend;

    assign running    = (st == PM_FULL) || (st == PM_ACTIVE);
    assign hib_exit   = (st == PM_HIBER) && (nxt == PM_FULL);
    assign full_entry = (st != PM_FULL) && (nxt == PM_FULL);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pll_en_q  <= 1'b1;
            byp_q     <= 1'b0;
            mult_pend <= MRST;
            mult_cur  <= MRST;
            lost      <= 1'b0;
        end else if (hib_exit) begin
            pll_en_q  <= 1'b1;
            byp_q     <= 1'b0;
            mult_pend <= MRST;
            mult_cur  <= MRST;
            lost      <= 1'b1;
        end else begin
            if (pll_wr && running) begin
                byp_q <= pll_wr_byp;
                if (st == PM_ACTIVE) pll_en_q <= pll_wr_en;
            end
            if (mult_we && running) mult_pend <= mult_wr;
            if (full_entry) mult_cur <= mult_pend;
        end
    end
endmodule

// File: rtl/pmc_dec.sv
module pmc_dec
    import pmc_pkg::*;
(
    input  pmode_e st,
    input  logic   pll_en_q,
    output rails_t rails,
    output logic   pll_on
);
    always_comb begin
        rails  = '0;
        pll_on = 1'b0;
        unique case (st)
            PM_FULL: begin
                rails  = '{cclk: 1'b1, sclk: 1'b1, vdd: 1'b1, hiz: 1'b0, dma: 1'b1};
                pll_on = pll_en_q;
            end
            PM_ACTIVE: begin
                rails  = '{cclk: 1'b1, sclk: 1'b1, vdd: 1'b1, hiz: 1'b0, dma: 1'b1};
                pll_on = pll_en_q;
            end
            PM_SLEEP: begin
                rails  = '{cclk: 1'b0, sclk: 1'b1, vdd: 1'b1, hiz: 1'b0, dma: 1'b0};
                pll_on = pll_en_q;
            end
            PM_DEEP: begin
                rails  = '{cclk: 1'b0, sclk: 1'b0, vdd: 1'b1, hiz: 1'b0, dma: 1'b0};
            end
            PM_HIBER: begin
                rails  = '{cclk: 1'b0, sclk: 1'b0, vdd: 1'b0, hiz: 1'b1, dma: 1'b0};
            end
            default: begin
                rails  = '0;
                pll_on = 1'b0;
            end
        endcase
    end
endmodule

// File: rtl/pwr_mode_ctrl.sv
module pwr_mode_ctrl
    import pmc_pkg::*;
#(
    parameter int unsigned MW       = 4,
    parameter int unsigned MULT_RST = 4,
    parameter int unsigned SYNC_N   = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          req_valid,
    input  logic [2:0]    req_code,
    input  logic          vr_we,
    input  logic [1:0]    vr_freq,
    input  logic          pll_wr,
    input  logic          pll_wr_en,
    input  logic          pll_wr_byp,
    input  logic          mult_we,
    input  logic [MW-1:0] mult_wr,
    input  logic          wake_gen,
    input  logic          wake_rtc,
    input  logic          wake_can,
    input  logic          wake_bus,
    input  logic          wake_gp,
    output logic [2:0]    mode,
    output logic          cclk_en,
    output logic          sclk_en,
    output logic          pll_on,
    output logic          pll_bypass,
    output logic          vdd_int_en,
    output logic          pads_hiz,
    output logic          dma_l1_ok,
    output logic [MW-1:0] mult_cur,
    output logic          state_lost
);
    logic [NWAKE-1:0] wk_raw;
    logic [NWAKE-1:0] wk;
    pmode_e           st;
    pmode_e           nxt;
    logic             pll_en_q;
    logic             byp_q;
    rails_t           rails;

    always_comb begin
        wk_raw        = '0;
        wk_raw[W_GEN] = wake_gen;
        wk_raw[W_RTC] = wake_rtc;
        wk_raw[W_CAN] = wake_can;
        wk_raw[W_BUS] = wake_bus;
        wk_raw[W_GP]  = wake_gp;
    end

    pmc_sync #(.N(NWAKE), .STAGES(SYNC_N)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (wk_raw),
        .q     (wk)
    );

    pmc_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_valid (req_valid),
        .req_code  (req_code),
        .vr_we     (vr_we),
        .vr_freq   (vr_freq),
        .pll_en_q  (pll_en_q),
        .byp_q     (byp_q),
        .wk        (wk),
        .st        (st),
        .nxt       (nxt)
    );

    pmc_cfg #(.MW(MW), .MULT_RST(MULT_RST)) u_cfg (
        .clk        (clk),
        .rst_n      (rst_n),
        .st         (st),
        .nxt        (nxt),
        .pll_wr     (pll_wr),
        .pll_wr_en  (pll_wr_en),
        .pll_wr_byp (pll_wr_byp),
        .mult_we    (mult_we),
        .mult_wr    (mult_wr),
        .pll_en_q   (pll_en_q),
        .byp_q      (byp_q),
        .mult_cur   (mult_cur),
        .lost       (state_lost)
    );

    pmc_dec u_dec (
        .st       (st),
        .pll_en_q (pll_en_q),
        .rails    (rails),
        .pll_on   (pll_on)
    );

    assign mode       = st;
    assign cclk_en    = rails.cclk;
    assign sclk_en    = rails.sclk;
    assign vdd_int_en = rails.vdd;
    assign pads_hiz   = rails.hiz;
    assign dma_l1_ok  = rails.dma;
    assign pll_bypass = byp_q;
endmodule

// File: rtl/pmc_chk.sv
module pmc_chk
    import pmc_pkg::*;
#(
    parameter int unsigned MW = 4
) (
    input logic          clk,
    input logic          rst_n,
    input logic [2:0]    mode,
    input logic          cclk_en,
    input logic          sclk_en,
    input logic          pll_on,
    input logic          vdd_int_en,
    input logic          pads_hiz,
    input logic          dma_l1_ok,
    input logic [MW-1:0] mult_cur,
    input logic          state_lost
);
    p_sleep_rails_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == PM_SLEEP) |-> (!cclk_en && sclk_en && pll_on && vdd_int_en));

    p_hiber_rails_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == PM_HIBER) |-> (!cclk_en && !sclk_en && !vdd_int_en && pads_hiz));

    p_deep_exit_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == PM_DEEP) |=> (mode == PM_DEEP || mode == PM_ACTIVE));

    p_full_pll_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == PM_FULL) |-> pll_on);

    p_refuse_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == PM_ACTIVE && !pll_on) |=> (mode != PM_FULL && mode != PM_SLEEP));

    p_mult_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(mult_cur) |-> (mode == PM_FULL && $past(mode) != PM_FULL));

    p_dma_r11: assert property (@(posedge clk) disable iff (!rst_n)
        dma_l1_ok |-> (mode == PM_FULL || mode == PM_ACTIVE));

    p_lost_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(state_lost) |-> ($past(mode) == PM_HIBER && mode == PM_FULL));
endmodule

bind pwr_mode_ctrl pmc_chk #(.MW(MW)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .mode       (mode),
    .cclk_en    (cclk_en),
    .sclk_en    (sclk_en),
    .pll_on     (pll_on),
    .vdd_int_en (vdd_int_en),
    .pads_hiz   (pads_hiz),
    .dma_l1_ok  (dma_l1_ok),
    .mult_cur   (mult_cur),
    .state_lost (state_lost)
);

// File: tb/sim_pwr_mode_ctrl.sv
module sim_pwr_mode_ctrl;
    localparam int MW = 4;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          req_valid = 1'b0;
    logic [2:0]    req_code = '0;
    logic          vr_we = 1'b0;
    logic [1:0]    vr_freq = 2'b11;
    logic          pll_wr = 1'b0;
    logic          pll_wr_en = 1'b1;
    logic          pll_wr_byp = 1'b0;
    logic          mult_we = 1'b0;
    logic [MW-1:0] mult_wr = '0;
    logic [4:0]    wake = '0;
    logic [2:0]    mode;
    logic          cclk_en, sclk_en, pll_on, pll_bypass, vdd_int_en, pads_hiz, dma_l1_ok;
    logic [MW-1:0] mult_cur;
    logic          state_lost;

    int n_chk = 0;
    int n_err = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    pwr_mode_ctrl #(.MW(MW), .MULT_RST(4)) u0 (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_code(req_code),
        .vr_we(vr_we), .vr_freq(vr_freq), .pll_wr(pll_wr), .pll_wr_en(pll_wr_en),
        .pll_wr_byp(pll_wr_byp), .mult_we(mult_we), .mult_wr(mult_wr),
        .wake_gen(wake[0]), .wake_rtc(wake[1]), .wake_can(wake[2]),
        .wake_bus(wake[3]), .wake_gp(wake[4]),
        .mode(mode), .cclk_en(cclk_en), .sclk_en(sclk_en), .pll_on(pll_on),
        .pll_bypass(pll_bypass), .vdd_int_en(vdd_int_en), .pads_hiz(pads_hiz),
        .dma_l1_ok(dma_l1_ok), .mult_cur(mult_cur), .state_lost(state_lost)
    );

    // vector: op[9:7] (0 req, 1 vr write, 2 pll write {en,byp}, 3 wake index), arg[6:3], expected mode[2:0]
    localparam int NV = 24;
    localparam logic [9:0] VEC [NV] = '{
        {3'd0, 4'd1, 3'd1},  // R2 Full On -> Active
        {3'd0, 4'd2, 3'd2},  // R2 Active -> Sleep
        {3'd3, 4'd0, 3'd0},  // R4 bypass clear -> Full On
        {3'd2, 4'd3, 3'd0},  // R8 set bypass in Full On
        {3'd0, 4'd2, 3'd2},  // R2 Full On -> Sleep
        {3'd3, 4'd1, 3'd1},  // R4 bypass set -> Active
        {3'd2, 4'd1, 3'd1},  // R8 disable PLL in Active
        {3'd0, 4'd0, 3'd1},  // R9 Full On refused
        {3'd0, 4'd2, 3'd1},  // R9 Sleep refused
        {3'd0, 4'd3, 3'd3},  // R2 Active -> Deep Sleep
        {3'd3, 4'd0, 3'd3},  // R5 generic wake ignored
        {3'd3, 4'd2, 3'd3},  // R5 CAN ignored
        {3'd3, 4'd1, 3'd1},  // R5 RTC -> Active
        {3'd2, 4'd2, 3'd1},  // R8 re-enable PLL, bypass clear
        {3'd0, 4'd7, 3'd1},  // R2 unused code ignored
        {3'd1, 4'd1, 3'd1},  // R6 nonzero regulator write ignored
        {3'd1, 4'd0, 3'd4},  // R6 Active -> Hibernate
        {3'd3, 4'd0, 3'd4},  // R7 generic wake ignored
        {3'd3, 4'd3, 3'd0},  // R7 bus-receive pin -> Full On
        {3'd0, 4'd3, 3'd3},  // R2 Full On -> Deep Sleep
        {3'd0, 4'd0, 3'd3},  // R2 request ignored in Deep Sleep
        {3'd3, 4'd1, 3'd1},  // R5 RTC -> Active
        {3'd1, 4'd0, 3'd4},  // R6 -> Hibernate
        {3'd3, 4'd4, 3'd0}   // R7 general-purpose wake -> Full On
    };

    function automatic logic [4:0] exp_rails(input logic [2:0] m);
        case (m)
            3'd0, 3'd1: return 5'b11101;
            3'd2:       return 5'b01100;
            3'd3:       return 5'b00100;
            default:    return 5'b00010;
        endcase
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic do_op(input logic [2:0] op, input logic [3:0] arg);
        @(negedge clk);
        case (op)
            3'd0: begin req_valid = 1'b1; req_code = arg[2:0]; end
            3'd1: begin vr_we = 1'b1; vr_freq = arg[1:0]; end
            3'd2: begin pll_wr = 1'b1; pll_wr_en = arg[1]; pll_wr_byp = arg[0]; end
            default: wake[arg[2:0]] = 1'b1;
        endcase
        @(negedge clk);
        req_valid = 1'b0; vr_we = 1'b0; pll_wr = 1'b0; mult_we = 1'b0; wake = '0;
        if (op == 3'd3) repeat (3) @(negedge clk);
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    initial begin
        #2000000;
        if (!done) begin
            done = 1'b1;
            n_chk++;
            n_err++;
            $display("FAIL watchdog actual=hung expected=finish");
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end

    initial begin
        do_reset();
        // R1 reset state
        check("R1 mode", mode, 0);
        check("R1 rails", {cclk_en, sclk_en, vdd_int_en, pads_hiz, dma_l1_ok}, 5'b11101);
        check("R1 pll", {pll_on, pll_bypass}, 2'b10);
        check("R1 mult", mult_cur, 4);
        check("R1 lost", state_lost, 0);

        for (int i = 0; i < NV; i++) begin
            do_op(VEC[i][9:7], VEC[i][6:3]);
            check($sformatf("R2 vec%0d mode", i), mode, VEC[i][2:0]);
            check($sformatf("R3 R11 vec%0d rails", i),
                  {cclk_en, sclk_en, vdd_int_en, pads_hiz, dma_l1_ok}, exp_rails(VEC[i][2:0]));
        end
        // after Hibernate exit
        check("R7 lost set", state_lost, 1);
        check("R7 pll restored", {pll_on, pll_bypass}, 2'b10);

        // R8: PLL disable refused in Full On
        do_op(3'd2, 4'd0);
        check("R8 pll held in Full On", pll_on, 1);
        do_op(3'd0, 4'd3);
        check("R8 pll off in Deep Sleep", pll_on, 0);
        do_reset();

        // R10: pending multiplier
        @(negedge clk); mult_we = 1'b1; mult_wr = 4'd9;
        @(negedge clk); mult_we = 1'b0;
        check("R10 held in Full On", mult_cur, 4);
        do_op(3'd0, 4'd1);
        check("R10 held in Active", mult_cur, 4);
        do_op(3'd0, 4'd0);
        check("R10 applied on Full On entry", mult_cur, 9);

        // R12: synchronizer latency
        do_op(3'd0, 4'd2);
        @(negedge clk); wake[0] = 1'b1;
        @(negedge clk); wake[0] = 1'b0;
        check("R12 after edge n", mode, 2);
        @(negedge clk);
        check("R12 after edge n+1", mode, 2);
        @(negedge clk);
        check("R12 after edge n+2", mode, 0);

        // R6: Hibernate write wins over a same-cycle request
        @(negedge clk); req_valid = 1'b1; req_code = 3'd1; vr_we = 1'b1; vr_freq = 2'b00;
        @(negedge clk); req_valid = 1'b0; vr_we = 1'b0;
        check("R6 priority", mode, 4);
        do_op(3'd3, 4'd2);
        check("R7 CAN wake", mode, 0);
        check("R7 mult reset", mult_cur, 4);

        // R1: asynchronous reset from Deep Sleep
        do_op(3'd0, 4'd3);
        check("R1 pre-reset", mode, 3);
        #2 rst_n = 1'b0;
        #1 check("R1 async reset", mode, 0);
        check("R1 lost cleared", state_lost, 0);
        @(negedge clk); rst_n = 1'b1;

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule